// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level translation table in memory. Each walk starts from a table base value, the virtual address, an access kind and a user/privileged flag. The first word read may describe a 4 MB superpage, which ends the walk. It may instead point at a second-level table. In that case a second word read yields a 4 KB page entry. The block returns the physical address, the read/write/execute grant bits taken from the final descriptor, a page-size flag and an 8-bit fault code, where zero means success.

The surrounding logic decides when a walk is needed and holds any cached translations. It pulses `start` while the walker is idle and serves the one-word reads on a plain request/response port. The request is a single-cycle pulse and the response may arrive any number of cycles later, at least one. The result is valid in the single cycle where `done` is high, and it stays on the result ports until the next walk ends.

Top module: `ptw_walker`

## Requirements
- R1: While reset is applied and just after it, `done`, `mem_req` and `busy` are low.
- R2: The cycle after a start is accepted, `mem_req` pulses with `mem_addr` = {base[31:12], VA[31:22], 2'b00}. Bits [11:0] of the base have no effect.
- R3: A first-level descriptor with type field [1:0] = 3 and present bit [2] set completes the walk after one read. It gives PA = {desc[31:22], VA[21:0]} and `res_super` = 1.
- R4: A first-level descriptor with type 0 and bit [2] set causes a second read at {desc[31:12], VA[21:12], 2'b00}. A second-level entry with bit [2] set and type 0 gives PA = {entry[31:12], VA[11:0]} and `res_super` = 0.
- R5: A missing superpage gives fault 0x0B, a missing second-level table gives 0x05 and a missing 4 KB page gives 0x08. No further read is made, and PA, grant bits and `res_super` are returned as zero.
- R6: `res_perm` is {bit 8, bit 7, bit 6} of the final descriptor, meaning {read, write, execute}.
- R7: The access kind is encoded as 0 read, 1 write, 2 execute and 3 reserved. A user access lacking the matching grant gives 0x11 for read, 0x12 for write and 0x13 for execute, while still returning PA, grants and size. Kind 3 never takes a grant fault.
- R8: A privileged access never takes a grant fault, whatever the grant bits are.
- R9: A first-level type of 1 or 2, or a present second-level entry whose type is not 0, gives fault 0x0F with zero PA, grants and size.
- R10: At most one read is outstanding. Every accepted start produces exactly one `done`, and `done` is a one-cycle pulse.
- R11: A `start` that arrives while `busy` is high is ignored. It produces no read and no result.
- R12: `done` rises in the cycle right after the edge that takes the final response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (accepted only when idle) |
| req_va | input | 32 | Virtual address to translate |
| req_base | input | 32 | Translation table base, bits [31:12] used |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| req_user | input | 1 | 1 = user access, 0 = privileged |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | One-cycle word read request |
| mem_addr | output | 32 | Word read address, valid with `mem_req` |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 32 | Read data (descriptor) |
| done | output | 1 | One-cycle completion pulse |
| res_pa | output | 32 | Translated physical address |
| res_perm | output | 3 | Grants {read, write, execute} |
| res_super | output | 1 | 1 = 4 MB superpage, 0 = 4 KB page |
| res_fault | output | 8 | Fault code, 0 = success |

## Verification
The assertions assume that the memory side raises `mem_rsp_valid` only while a read is outstanding, at least one cycle after the request, and for exactly one cycle. They also assume that the request inputs are stable in the cycle a start is accepted. The bench memory model follows these rules: it answers each `mem_req` once, after a latency that cycles from one to three cycles, and it changes the request inputs only at falling edges. The single test that breaks the idle-only start rule, by pulsing `start` during a walk, leaves the memory protocol untouched. This keeps all the assumptions intact while the walker's rejection of that start is observed.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;

  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned FAULT_W   = 8;
  localparam int unsigned PERM_W    = 3;
  localparam int unsigned PG_SHIFT  = 12;
  localparam int unsigned SP_SHIFT  = 22;
  localparam int unsigned IDX_W     = SP_SHIFT - PG_SHIFT;
  localparam int unsigned BIT_PRES  = 2;
  localparam int unsigned BIT_RD    = 8;
  localparam int unsigned BIT_WR    = 7;
  localparam int unsigned BIT_EX    = 6;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    DK_TABLE = 2'd0,
    DK_RSV1  = 2'd1,
    DK_RSV2  = 2'd2,
    DK_SUPER = 2'd3
  } dkind_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_L1_REQ  = 3'd1,
    ST_L1_WAIT = 3'd2,
    ST_L2_REQ  = 3'd3,
    ST_L2_WAIT = 3'd4
  } walk_st_e;

  typedef logic [FAULT_W-1:0] fault_t;

  localparam fault_t FLT_NONE     = 8'h00;
  localparam fault_t FLT_TBL_MISS = 8'h05;
  localparam fault_t FLT_PG_MISS  = 8'h08;
  localparam fault_t FLT_SP_MISS  = 8'h0B;
  localparam fault_t FLT_BAD_KIND = 8'h0F;
  localparam fault_t FLT_NO_RD    = 8'h11;
  localparam fault_t FLT_NO_WR    = 8'h12;
  localparam fault_t FLT_NO_EX    = 8'h13;

  typedef struct packed {
    logic [ADDR_W-1:0] pa;
    logic [PERM_W-1:0] perm;
    logic              super_pg;
    fault_t            fault;
  } walk_res_t;

  function automatic logic [ADDR_W-1:0] l1_ptr(input logic [ADDR_W-1:0] base,
                                               input logic [ADDR_W-1:0] va);
    l1_ptr = {base[ADDR_W-1:PG_SHIFT], va[ADDR_W-1:SP_SHIFT], 2'b00};
  endfunction

  function automatic logic [ADDR_W-1:0] l2_ptr(input logic [ADDR_W-1:0] tdesc,
                                               input logic [ADDR_W-1:0] va);
    l2_ptr = {tdesc[ADDR_W-1:PG_SHIFT], va[SP_SHIFT-1:PG_SHIFT], 2'b00};
  endfunction

  function automatic logic [ADDR_W-1:0] sp_phys(input logic [ADDR_W-1:0] d,
                                                input logic [ADDR_W-1:0] va);
    sp_phys = {d[ADDR_W-1:SP_SHIFT], va[SP_SHIFT-1:0]};
  endfunction

  function automatic logic [ADDR_W-1:0] pg_phys(input logic [ADDR_W-1:0] d,
                                                input logic [ADDR_W-1:0] va);
    pg_phys = {d[ADDR_W-1:PG_SHIFT], va[PG_SHIFT-1:0]};
  endfunction

  function automatic logic [PERM_W-1:0] grant_bits(input logic [ADDR_W-1:0] d);
    grant_bits = {d[BIT_RD], d[BIT_WR], d[BIT_EX]};
  endfunction

  function automatic fault_t grant_check(input logic [PERM_W-1:0] g,
                                         input acc_e acc, input logic user);
    grant_check = FLT_NONE;
    if (user) begin
      case (acc)
        ACC_RD:  if (!g[2]) grant_check = FLT_NO_RD;
        ACC_WR:  if (!g[1]) grant_check = FLT_NO_WR;
        ACC_EX:  if (!g[0]) grant_check = FLT_NO_EX;
        default: grant_check = FLT_NONE;
      endcase
    end
  endfunction

endpackage

// File: rtl/ptw_seq.sv
`timescale 1ns/1ps
module ptw_seq
  import ptw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rsp_valid,
  input  logic need_l2,
  output logic start_accept,
  output logic mem_req,
  output logic in_l2,
  output logic latch_l1,
  output logic walk_finish,
  output logic busy
);

  walk_st_e st_q, st_d;

  assign start_accept = start && (st_q == ST_IDLE);
  assign mem_req      = (st_q == ST_L1_REQ) || (st_q == ST_L2_REQ);
  assign in_l2        = (st_q == ST_L2_REQ) || (st_q == ST_L2_WAIT);
  assign latch_l1     = (st_q == ST_L1_WAIT) && rsp_valid && need_l2;
  assign walk_finish  = rsp_valid &&
                        (((st_q == ST_L1_WAIT) && !need_l2) || (st_q == ST_L2_WAIT));
  assign busy         = (st_q != ST_IDLE);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:    if (start) st_d = ST_L1_REQ;
      ST_L1_REQ:  st_d = ST_L1_WAIT;
      ST_L1_WAIT: if (rsp_valid) st_d = need_l2 ? ST_L2_REQ : ST_IDLE;
      ST_L2_REQ:  st_d = ST_L2_WAIT;
      ST_L2_WAIT: if (rsp_valid) st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/ptw_desc_eval.sv
`timescale 1ns/1ps
module ptw_desc_eval
  import ptw_pkg::*;
(
  input  logic              level2,
  input  logic [ADDR_W-1:0] desc,
  input  logic [ADDR_W-1:0] va,
  input  acc_e              acc,
  input  logic              user,
  output logic              need_l2,
  output walk_res_t         res
);

  logic   present;
  dkind_e kind;

  assign present = desc[BIT_PRES];
  assign kind    = dkind_e'(desc[1:0]);

  always_comb begin
    res     = '0;
    need_l2 = 1'b0;
    if (!level2) begin
      case (kind)
        DK_SUPER: begin
          if (!present) begin
            res.fault = FLT_SP_MISS;
          end else begin
            res.pa       = sp_phys(desc, va);
            res.perm     = grant_bits(desc);
            res.super_pg = 1'b1;
            res.fault    = grant_check(grant_bits(desc), acc, user);
          end
        end
        DK_TABLE: begin
          if (!present) res.fault = FLT_TBL_MISS;
          else          need_l2   = 1'b1;
        end
        default: res.fault = FLT_BAD_KIND;
      endcase
    end else begin
      if (!present) begin
        res.fault = FLT_PG_MISS;
      end else if (kind != DK_TABLE) begin
        res.fault = FLT_BAD_KIND;
      end else begin
        res.pa    = pg_phys(desc, va);
        res.perm  = grant_bits(desc);
        res.fault = grant_check(grant_bits(desc), acc, user);
      end
    end
  end

endmodule

// File: rtl/ptw_result_hold.sv
`timescale 1ns/1ps
module ptw_result_hold
  import ptw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  walk_res_t res_in,
  output logic      done,
  output walk_res_t res_out
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      res_out <= '0;
    end else begin
      done <= load;
      if (load) res_out <= res_in;
    end
  end

endmodule

// File: rtl/ptw_walker.sv
`timescale 1ns/1ps
module ptw_walker
  import ptw_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [ADDR_W-1:0]   req_va,
  input  logic [ADDR_W-1:0]   req_base,
  input  logic [1:0]          req_acc,
  input  logic                req_user,
  output logic                busy,
  output logic                mem_req,
  output logic [ADDR_W-1:0]   mem_addr,
  input  logic                mem_rsp_valid,
  input  logic [ADDR_W-1:0]   mem_rsp_data,
  output logic                done,
  output logic [ADDR_W-1:0]   res_pa,
  output logic [PERM_W-1:0]   res_perm,
  output logic                res_super,
  output logic [FAULT_W-1:0]  res_fault
);

  logic              start_accept;
  logic              walk_finish;
  logic              need_l2;
  logic              in_l2;
  logic              latch_l1;
  logic [ADDR_W-1:0] va_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] l1d_q;
  acc_e              acc_q;
  logic              user_q;
  walk_res_t         eval_res;
  walk_res_t         held_res;

  ptw_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .rsp_valid    (mem_rsp_valid),
    .need_l2      (need_l2),
    .start_accept (start_accept),
    .mem_req      (mem_req),
    .in_l2        (in_l2),
    .latch_l1     (latch_l1),
    .walk_finish  (walk_finish),
    .busy         (busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q   <= '0;
      base_q <= '0;
      acc_q  <= ACC_RD;
      user_q <= 1'b0;
      l1d_q  <= '0;
    end else begin
      if (start_accept) begin
        va_q   <= req_va;
        base_q <= req_base;
        acc_q  <= acc_e'(req_acc);
        user_q <= req_user;
      end
      if (latch_l1) l1d_q <= mem_rsp_data;
    end
  end

  assign mem_addr = in_l2 ? l2_ptr(l1d_q, va_q) : l1_ptr(base_q, va_q);

  ptw_desc_eval u_eval (
    .level2  (in_l2),
    .desc    (mem_rsp_data),
    .va      (va_q),
    .acc     (acc_q),
    .user    (user_q),
    .need_l2 (need_l2),
    .res     (eval_res)
  );

  ptw_result_hold u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (walk_finish),
    .res_in  (eval_res),
    .done    (done),
    .res_out (held_res)
  );

  assign res_pa    = held_res.pa;
  assign res_perm  = held_res.perm;
  assign res_super = held_res.super_pg;
  assign res_fault = held_res.fault;

endmodule

// File: rtl/ptw_walker_chk.sv
`timescale 1ns/1ps
module ptw_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic [31:0] req_va,
  input logic [31:0] req_base,
  input logic        req_user,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        mem_rsp_valid,
  input logic        done,
  input logic [31:0] res_pa,
  input logic [2:0]  res_perm,
  input logic        res_super,
  input logic [7:0]  res_fault,
  input logic        start_accept,
  input logic        walk_finish
);

  logic outst;
  logic user_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst  <= 1'b0;
      user_c <= 1'b0;
    end else begin
      if (mem_req)            outst <= 1'b1;
      else if (mem_rsp_valid) outst <= 1'b0;
      if (start_accept) user_c <= req_user;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  assert_l1_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_accept |=> (mem_req &&
      mem_addr == {$past(req_base[31:12]), $past(req_va[31:22]), 2'b00}));

  assert_miss_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (res_fault == 8'h0B || res_fault == 8'h05 || res_fault == 8'h08))
      |-> (res_pa == 32'h0 && res_perm == 3'b000 && !res_super));

  assert_priv_no_grant_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !user_c) |-> !(res_fault == 8'h11 || res_fault == 8'h12 || res_fault == 8'h13));

  assert_single_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !outst);

  assert_rsp_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> outst);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |-> !start_accept);

  assert_done_after_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    walk_finish |=> done);

  assert_done_has_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_rsp_valid));

endmodule

bind ptw_walker ptw_walker_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .busy          (busy),
  .req_va        (req_va),
  .req_base      (req_base),
  .req_user      (req_user),
  .mem_req       (mem_req),
  .mem_addr      (mem_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .done          (done),
  .res_pa        (res_pa),
  .res_perm      (res_perm),
  .res_super     (res_super),
  .res_fault     (res_fault),
  .start_accept  (start_accept),
  .walk_finish   (walk_finish)
);

// File: tb/sim_ptw_walker.sv
`timescale 1ns/1ps
module sim_ptw_walker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] req_va = '0;
  logic [31:0] req_base = '0;
  logic [1:0]  req_acc = '0;
  logic        req_user = 1'b0;
  logic        busy;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done;
  logic [31:0] res_pa;
  logic [2:0]  res_perm;
  logic        res_super;
  logic [7:0]  res_fault;

  always #5 clk = ~clk;

  ptw_walker u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .req_va(req_va), .req_base(req_base),
    .req_acc(req_acc), .req_user(req_user), .busy(busy), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .res_pa(res_pa), .res_perm(res_perm), .res_super(res_super),
    .res_fault(res_fault)
  );

  typedef struct {
    logic [31:0] pa;
    logic [2:0]  perm;
    logic        sup;
    logic [7:0]  fault;
    int          nrd;
    logic [31:0] a1;
    logic [31:0] a2;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] mem [logic [31:0]];
  int          checks = 0;
  int          fails = 0;
  int          cyc = 0;
  int          last_rsp_cyc = -10;
  logic [31:0] seen0 = '0;
  logic [31:0] seen1 = '0;
  int          seen_n = 0;
  int          lat_sel = 0;

  always @(posedge clk) cyc++;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] mk(input logic [31:0] hi, input bit r, input bit w,
                                     input bit x, input bit p, input logic [1:0] ty);
    return (hi & 32'hFFFF_F000) | (32'(r) << 8) | (32'(w) << 7) | (32'(x) << 6) |
           (32'(p) << 2) | 32'(ty);
  endfunction

  task automatic put_l1(input logic [31:0] base, input logic [31:0] va, input logic [31:0] d);
    mem[{base[31:12], va[31:22], 2'b00}] = d;
  endtask

  task automatic put_l2(input logic [31:0] tbl, input logic [31:0] va, input logic [31:0] d);
    mem[{tbl[31:12], va[21:12], 2'b00}] = d;
  endtask

  function automatic logic [7:0] grant_rule(input logic [2:0] g, input logic [1:0] acc,
                                           input bit user);
    if (!user) return 8'h00;
    if (acc == 2'd0 && !g[2]) return 8'h11;
    if (acc == 2'd1 && !g[1]) return 8'h12;
    if (acc == 2'd2 && !g[0]) return 8'h13;
    return 8'h00;
  endfunction

  function automatic exp_t model(input logic [31:0] va, input logic [31:0] base,
                                 input logic [1:0] acc, input bit user, input string tag);
    exp_t e;
    logic [31:0] d1;
    logic [31:0] d2;
    e.pa = '0; e.perm = '0; e.sup = 1'b0; e.fault = '0; e.tag = tag;
    e.a1 = {base[31:12], va[31:22], 2'b00};
    e.a2 = '0;
    e.nrd = 1;
    d1 = rd(e.a1);
    if (d1[1:0] == 2'b11) begin
      if (!d1[2]) e.fault = 8'h0B;
      else begin
        e.pa = {d1[31:22], va[21:0]};
        e.perm = {d1[8], d1[7], d1[6]};
        e.sup = 1'b1;
        e.fault = grant_rule(e.perm, acc, user);
      end
    end else if (d1[1:0] == 2'b00) begin
      if (!d1[2]) e.fault = 8'h05;
      else begin
        e.nrd = 2;
        e.a2 = {d1[31:12], va[21:12], 2'b00};
        d2 = rd(e.a2);
        if (!d2[2]) e.fault = 8'h08;
        else if (d2[1:0] != 2'b00) e.fault = 8'h0F;
        else begin
          e.pa = {d2[31:12], va[11:0]};
          e.perm = {d2[8], d2[7], d2[6]};
          e.fault = grant_rule(e.perm, acc, user);
        end
      end
    end else begin
      e.fault = 8'h0F;
    end
    return e;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // memory responder: one answer per request, latency 1..3 cycles
  initial begin
    @(posedge clk); #1;
    forever begin
      if (!(rst_n && mem_req)) begin
        @(posedge clk); #1;
      end else begin
        logic [31:0] a;
        int lat;
        a = mem_addr;
        if (seen_n == 0) seen0 = a;
        else if (seen_n == 1) seen1 = a;
        seen_n++;
        lat = 1 + (lat_sel % 3);
        lat_sel++;
        repeat (lat) @(posedge clk);
        #1;
        mem_rsp_valid = 1'b1;
        mem_rsp_data = rd(a);
        @(posedge clk); #1;
        last_rsp_cyc = cyc;
        mem_rsp_valid = 1'b0;
        mem_rsp_data = '0;
      end
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (sb.size() == 0) begin
          checks++; fails++;
          $display("FAIL R11 unexpected done actual=1 expected=0");
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(e.tag, "fault", 32'(res_fault), 32'(e.fault));
          chk(e.tag, "pa", res_pa, e.pa);
          chk("R6", "perm", 32'(res_perm), 32'(e.perm));
          chk(e.tag, "size", 32'(res_super), 32'(e.sup));
          chk("R10", "reads", 32'(seen_n), 32'(e.nrd));
          chk("R2", "l1 addr", seen0, e.a1);
          if (e.nrd == 2) chk("R4", "l2 addr", seen1, e.a2);
          chk("R12", "done cycle", 32'(cyc), 32'(last_rsp_cyc));
          seen_n = 0;
        end
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic [31:0] base, input logic [1:0] acc,
                      input bit user, input string tag);
    do @(negedge clk); while (sb.size() != 0 || busy);
    sb.push_back(model(va, base, acc, user, tag));
    req_va = va; req_base = base; req_acc = acc; req_user = user;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  localparam logic [31:0] B0  = 32'h0004_0ABC;
  localparam logic [31:0] B1  = 32'h0009_9123;
  localparam logic [31:0] TBL = 32'h0007_3000;

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1", "done", 32'(done), 32'h0);
    chk("R1", "mem_req", 32'(mem_req), 32'h0);
    chk("R1", "busy", 32'(busy), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy after reset", 32'(busy), 32'h0);

    // descriptor tables
    put_l1(B0, 32'h8123_4567, mk(32'h5AC0_0000, 1, 1, 0, 1, 2'd3));
    put_l1(B0, 32'h9000_0000, mk(32'h1240_0000, 1, 1, 1, 0, 2'd3));
    put_l1(B0, 32'h4050_0010, mk(TBL, 0, 0, 0, 1, 2'd0));
    put_l2(TBL, 32'h4050_0010, mk(32'h1234_5000, 1, 1, 1, 1, 2'd0));
    put_l2(TBL, 32'h4050_2000, mk(32'h2000_1000, 0, 1, 1, 1, 2'd0));
    put_l2(TBL, 32'h4050_3000, mk(32'h2000_2000, 1, 0, 1, 1, 2'd0));
    put_l2(TBL, 32'h4050_4000, mk(32'h2000_3000, 1, 1, 0, 1, 2'd0));
    put_l2(TBL, 32'h4050_5000, mk(32'h2000_4000, 1, 1, 1, 1, 2'd2));
    put_l2(TBL, 32'h4050_6000, mk(32'h2000_5000, 1, 0, 1, 1, 2'd0));
    put_l1(B0, 32'hC000_1234, mk(32'h3FC0_0000, 0, 0, 0, 1, 2'd3));
    put_l1(B0, 32'h2000_0000, mk(32'h0, 1, 1, 1, 1, 2'd1));
    put_l1(B1, 32'h8123_4567, mk(32'h7F80_0000, 1, 0, 0, 1, 2'd3));

    walk(32'h8123_4567, B0, 2'd0, 1'b1, "R3");  // superpage user read ok
    walk(32'h4050_0010, B0, 2'd1, 1'b1, "R4");  // 4K page user write ok
    walk(32'h9000_0000, B0, 2'd0, 1'b1, "R5");  // superpage missing 0B
    walk(32'h1000_0000, B0, 2'd0, 1'b0, "R5");  // table missing 05
    walk(32'h4050_1000, B0, 2'd2, 1'b1, "R5");  // page missing 08
    walk(32'h4050_2000, B0, 2'd0, 1'b1, "R7");  // no read 11
    walk(32'h4050_3000, B0, 2'd1, 1'b1, "R7");  // no write 12
    walk(32'h4050_4000, B0, 2'd2, 1'b1, "R7");  // no exec 13
    walk(32'h4050_2000, B0, 2'd3, 1'b1, "R7");  // reserved kind, no fault
    walk(32'h4050_4000, B0, 2'd2, 1'b0, "R8");  // privileged exec, no fault
    walk(32'hC000_1234, B0, 2'd1, 1'b0, "R8");  // privileged write, zero grants
    walk(32'h2000_0000, B0, 2'd0, 1'b1, "R9");  // bad first-level type
    walk(32'h4050_5000, B0, 2'd0, 1'b1, "R9");  // bad second-level type
    walk(32'h4050_6000, B0, 2'd0, 1'b0, "R6");  // grant bit order
    walk(32'h8123_4567, B1, 2'd2, 1'b0, "R2");  // other base, low base bits ignored

    // R11: start during a walk is ignored
    walk(32'h8123_4567, B0, 2'd0, 1'b1, "R11");
    req_va = 32'h9000_0000; req_acc = 2'd2;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
    chk("R11", "pending results", 32'(sb.size()), 32'h0);
    chk("R11", "busy after ignored start", 32'(busy), 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule